// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one vector memory instruction into a stream of per-element byte addresses for a banked memory crossbar. A request carries a base address, an addressing mode, an element width, a requested vector length, a constant stride, a per-element index offset source and a base increment. Once the request is accepted, the block emits up to `LANES` addresses per cycle, in element order. Each address goes out with the bank number that a downstream conflict arbiter needs.

The block counts element requests that have been issued but not yet completed. It stops issuing when that count would pass `MAX_OUT`. The requested length is cut down to the maximum vector length for the chosen element width. When the last element has been issued, the base register advances by the increment value and a one-cycle `done` pulse is raised. In indexed mode, the index source supplies the offset for element `req_elem + l` on lane `l` in the same cycle.

Top module: `vec_agen`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid`, `outstanding` and `base_reg` are all zero.
- R2: With `mode` 0 (unit stride) or 3 (treated as unit stride), element e has address base + e * 2^ewidth, where `ewidth` 0/1/2/3 selects 8/16/32/64-bit elements.
- R3: With `mode` 1 (constant stride), element e has address base + e * stride, computed modulo 2^ADDR_W, and a negative stride (two's complement) is allowed.
- R4: With `mode` 2 (indexed), element e has address base + idx_off lane l, where lane l carries element `req_elem` + l.
- R5: In each cycle the valid lanes are contiguous from lane 0, and lane l carries element `req_elem` + l. The valid count is min(LANES, elements left, MAX_OUT − outstanding). `req_elem` starts at 0.
- R6: The number of elements issued is min(vlen, MVL), where MVL is 128, 128, 64 or 32 for `ewidth` 0, 1, 2 or 3.
- R7: The bank of each address is its byte-address bits [OFF_BITS +: log2(NBANKS)], which is bits [5:3] by default.
- R8: `outstanding` rises by the number of valid lanes and falls by `cpl_cnt` one cycle later. It never exceeds MAX_OUT, and no lane is valid while it equals MAX_OUT.
- R9: The cycle after the last element issues, `done` is high for exactly one cycle, `busy` falls, and `base_reg` equals base + incr.
- R10: A `start` while `busy` is high is ignored, and the addresses and final base of the running operation are unchanged.
- R11: A vector length of 0 issues no request and still completes with `done` and the base increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new operation when idle |
| mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 unit |
| ewidth | input | 2 | Element width select 8/16/32/64 bits |
| base_in | input | ADDR_W | Start base address |
| stride_in | input | ADDR_W | Byte stride for strided mode |
| incr_in | input | ADDR_W | Base increment applied at completion |
| vlen | input | VL_W | Requested element count |
| idx_off | input | LANES*ADDR_W | Index offsets, lane l for element req_elem+l |
| cpl_cnt | input | LN_W | Completions returned this cycle |
| req_valid | output | LANES | Lane carries an element request |
| req_elem | output | VL_W | Element number on lane 0 |
| req_addr | output | LANES*ADDR_W | Byte address per lane |
| req_bank | output | LANES*BANK_W | Bank number per lane |
| outstanding | output | CNT_W | Issued but uncompleted requests |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| base_reg | output | ADDR_W | Base register, auto-incremented |

## Verification
The bench builds the block with a 16-bit address and `MAX_OUT` set to 16, keeping the other values at their defaults. With that limit, a single 128-element operation fills the outstanding window and exercises the stall in R8 both while completions are held back and while they are streamed. The bench sweeps every mode code, every element width and a range of lengths across the MVL limits: 0, 1, 5, 32, 33, 64, 65, 128 and 200. The narrow address makes wrap-around with a negative stride easy to reach.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_ALT    = 2'd3
  } amode_e;

  // Longest vector for an element-width code: register bytes over element
  // bytes, capped at the length counter's limit.
  function automatic int mvl_of(input int wsel, input int reg_bytes, input int cap);
    int lim;
    lim = reg_bytes >> wsel;
    if (lim > cap) lim = cap;
    return lim;
  endfunction

endpackage

// File: rtl/vag_lane.sv
module vag_lane
  import vag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int VL_W     = 8,
  parameter int BANK_W   = 3,
  parameter int OFF_BITS = 3
) (
  input  amode_e              mode,
  input  logic [1:0]          ewidth,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   stride,
  input  logic [ADDR_W-1:0]   idx,
  input  logic [VL_W-1:0]     elem,
  output logic [ADDR_W-1:0]   addr,
  output logic [BANK_W-1:0]   bank
);

  function automatic logic [ADDR_W-1:0] lane_addr(
    input amode_e m, input logic [1:0] w, input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] ix, input logic [VL_W-1:0] e);
    logic [ADDR_W-1:0] e_ext;
    e_ext = {{(ADDR_W-VL_W){1'b0}}, e};
    unique case (m)
      AM_STRIDE: return b + e_ext * s;
      AM_INDEX:  return b + ix;
      default:   return b + (e_ext << w);
    endcase
  endfunction

  assign addr = lane_addr(mode, ewidth, base, stride, idx, elem);
  assign bank = addr[OFF_BITS +: BANK_W];

endmodule

// File: rtl/vag_track.sv
module vag_track #(
  parameter int MAX_OUT = 64,
  parameter int LN_W    = 3,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LN_W-1:0]  issue_n,
  input  logic [LN_W-1:0]  cpl_n,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] room
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(issue_n) - CNT_W'(cpl_n);
  end

  assign cnt  = cnt_q;
  assign room = CNT_W'(MAX_OUT) - cnt_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_OUT);

  assert_cpl_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(cpl_n) <= cnt_q);

endmodule

// File: rtl/vec_agen.sv
module vec_agen
  import vag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LANES     = 4,
  parameter int VL_W      = 8,
  parameter int MAX_OUT   = 64,
  parameter int NBANKS    = 8,
  parameter int OFF_BITS  = 3,
  parameter int REG_BYTES = 256,
  parameter int MVL_CAP   = 128,
  localparam int BANK_W   = $clog2(NBANKS),
  localparam int LN_W     = $clog2(LANES + 1),
  localparam int CNT_W    = $clog2(MAX_OUT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               mode,
  input  logic [1:0]               ewidth,
  input  logic [ADDR_W-1:0]        base_in,
  input  logic [ADDR_W-1:0]        stride_in,
  input  logic [ADDR_W-1:0]        incr_in,
  input  logic [VL_W-1:0]          vlen,
  input  logic [LANES*ADDR_W-1:0]  idx_off,
  input  logic [LN_W-1:0]          cpl_cnt,
  output logic [LANES-1:0]         req_valid,
  output logic [VL_W-1:0]          req_elem,
  output logic [LANES*ADDR_W-1:0]  req_addr,
  output logic [LANES*BANK_W-1:0]  req_bank,
  output logic [CNT_W-1:0]         outstanding,
  output logic                     busy,
  output logic                     done,
  output logic [ADDR_W-1:0]        base_reg
);

  amode_e            mode_q;
  logic [1:0]        width_q;
  logic [ADDR_W-1:0] base_q, stride_q, incr_q;
  logic [VL_W-1:0]   vl_q, elem_q;
  logic              busy_q, done_q;

  // Named internal events for the assertions
  logic              start_acc;
  logic              finish;
  logic [LN_W-1:0]   issue_n;
  logic [CNT_W-1:0]  room;
  logic [VL_W-1:0]   vl_clamp;

  function automatic logic [VL_W-1:0] clamp_len(input logic [VL_W-1:0] req, input logic [1:0] w);
    int lim;
    lim = mvl_of(int'(w), REG_BYTES, MVL_CAP);
    return (int'(req) > lim) ? VL_W'(lim) : req;
  endfunction

  function automatic int issue_count(input int left, input int space);
    int c;
    c = LANES;
    if (left < c)  c = left;
    if (space < c) c = space;
    return c;
  endfunction

  assign start_acc = start && !busy_q;
  assign vl_clamp  = clamp_len(vlen, ewidth);
  assign issue_n   = busy_q ? LN_W'(issue_count(int'(vl_q) - int'(elem_q), int'(room))) : '0;
  assign finish    = busy_q && (int'(elem_q) + int'(issue_n) == int'(vl_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= AM_UNIT;
      width_q  <= '0;
      base_q   <= '0;
      stride_q <= '0;
      incr_q   <= '0;
      vl_q     <= '0;
      elem_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_acc) begin
        mode_q   <= amode_e'(mode);
        width_q  <= ewidth;
        base_q   <= base_in;
        stride_q <= stride_in;
        incr_q   <= incr_in;
        vl_q     <= vl_clamp;
        elem_q   <= '0;
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        elem_q <= elem_q + VL_W'(issue_n);
        if (finish) begin
          busy_q <= 1'b0;
          base_q <= base_q + incr_q;
        end
      end
    end
  end

  vag_track #(.MAX_OUT(MAX_OUT), .LN_W(LN_W), .CNT_W(CNT_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_n (issue_n),
    .cpl_n   (cpl_cnt),
    .cnt     (outstanding),
    .room    (room)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [VL_W-1:0] e_l;
    assign e_l          = elem_q + VL_W'(l);
    assign req_valid[l] = (LN_W'(l) < issue_n);

    vag_lane #(.ADDR_W(ADDR_W), .VL_W(VL_W), .BANK_W(BANK_W), .OFF_BITS(OFF_BITS)) u_lane (
      .mode   (mode_q),
      .ewidth (width_q),
      .base   (base_q),
      .stride (stride_q),
      .idx    (idx_off[l*ADDR_W +: ADDR_W]),
      .elem   (e_l),
      .addr   (req_addr[l*ADDR_W +: ADDR_W]),
      .bank   (req_bank[l*BANK_W +: BANK_W])
    );

    assert_within_mvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[l] |-> (int'(e_l) < mvl_of(int'(width_q), REG_BYTES, MVL_CAP)));
  end

  assign req_elem = elem_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign base_reg = base_q;

  assert_contiguous_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & (req_valid + LANES'(1))) == '0);

  assert_stall_at_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(outstanding) == MAX_OUT) |-> (req_valid == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_base_bump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (base_reg == $past(base_reg) + $past(incr_q)));

  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(vl_q) && $stable(mode_q) && $stable(stride_q)));

  assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen == '0) |=> (busy && req_valid == '0));

endmodule

// File: tb/tb_vec_agen.sv
module tb_vec_agen;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int LANES = 4;
  localparam int VLW   = 8;
  localparam int MAXO  = 16;
  localparam int BW    = 3;
  localparam int LNW   = 3;
  localparam int CW    = 5;

  logic                  clk, rst_n, start;
  logic [1:0]            mode, ewidth;
  logic [AW-1:0]         base_in, stride_in, incr_in;
  logic [VLW-1:0]        vlen;
  logic [LANES*AW-1:0]   idx_off;
  logic [LNW-1:0]        cpl_cnt;
  logic [LANES-1:0]      req_valid;
  logic [VLW-1:0]        req_elem;
  logic [LANES*AW-1:0]   req_addr;
  logic [LANES*BW-1:0]   req_bank;
  logic [CW-1:0]         outstanding;
  logic                  busy, done;
  logic [AW-1:0]         base_reg;

  int n_vec = 0;
  int n_bad = 0;
  int exp_out = 0;

  vec_agen #(.ADDR_W(AW), .LANES(LANES), .VL_W(VLW), .MAX_OUT(MAXO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ewidth(ewidth),
    .base_in(base_in), .stride_in(stride_in), .incr_in(incr_in), .vlen(vlen),
    .idx_off(idx_off), .cpl_cnt(cpl_cnt), .req_valid(req_valid), .req_elem(req_elem),
    .req_addr(req_addr), .req_bank(req_bank), .outstanding(outstanding),
    .busy(busy), .done(done), .base_reg(base_reg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Index register model: offset for element e
  function automatic logic [AW-1:0] idx_fn(input int e);
    return AW'(e * e * 7 + e * 13 + 3);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_idx
    assign idx_off[l*AW +: AW] = idx_fn(int'(req_elem) + l);
  end

  function automatic logic [AW-1:0] exp_addr(input int m, input int w, input logic [AW-1:0] b,
                                             input logic [AW-1:0] s, input int e);
    if (m == 1) return b + AW'(e) * s;
    if (m == 2) return b + idx_fn(e);
    return b + AW'(e * (1 << w));
  endfunction

  function automatic int exp_count(input int w, input int vl);
    int lim;
    case (w)
      0, 1:    lim = 128;
      2:       lim = 64;
      default: lim = 32;
    endcase
    return (vl < lim) ? vl : lim;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_op(input int m, input int w, input logic [AW-1:0] b, input logic [AW-1:0] s,
                        input logic [AW-1:0] inc, input int vl, input bit hold, input bit poke);
    int cnt, e, guard, nv, want, cpl;
    bit releasing, seen;
    cnt = exp_count(w, vl);
    e = 0; guard = 0; releasing = 0; seen = 0;
    @(negedge clk);
    start = 1'b1; mode = 2'(m); ewidth = 2'(w);
    base_in = b; stride_in = s; incr_in = inc; vlen = VLW'(vl);
    @(negedge clk);
    start = 1'b0;
    while (!seen && guard < 3000) begin
      chk(int'(outstanding) == exp_out, "R8 outstanding", int'(outstanding), exp_out);
      if (poke && guard == 0) begin
        start = 1'b1; base_in = b ^ 16'h5a5a; vlen = 8'd3; mode = 2'(m ^ 1); stride_in = s + 16'd8;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        chk(e == cnt, "R6 element count", e, cnt);
        chk(base_reg == b + inc, "R9 base increment", int'(base_reg), int'(b + inc));
        if (poke) chk(base_reg == b + inc, "R10 start ignored", int'(base_reg), int'(b + inc));
        if (cnt == 0) chk(1'b1, "R11 zero length completes", 0, 0);
        chk(req_valid == '0, "R9 idle at done", int'(req_valid), 0);
        seen = 1;
        nv = 0;
      end else begin
        nv = $countones(req_valid);
        want = imin(LANES, imin(cnt - e, MAXO - exp_out));
        chk(nv == want, "R5/R8 lane count", nv, want);
        chk(((req_valid & (req_valid + 4'd1)) == '0), "R5 contiguous", int'(req_valid), 0);
        chk(int'(req_elem) == e, "R5 element order", int'(req_elem), e);
        for (int l = 0; l < nv; l++) begin
          logic [AW-1:0] ea, aa;
          ea = exp_addr(m, w, b, s, e + l);
          aa = req_addr[l*AW +: AW];
          case (m)
            1:       chk(aa == ea, "R3 strided address", int'(aa), int'(ea));
            2:       chk(aa == ea, "R4 indexed address", int'(aa), int'(ea));
            default: chk(aa == ea, "R2 unit address", int'(aa), int'(ea));
          endcase
          chk(req_bank[l*BW +: BW] == ea[5:3], "R7 bank", int'(req_bank[l*BW +: BW]), int'(ea[5:3]));
        end
        e += nv;
      end
      if (hold && !releasing && exp_out == MAXO) releasing = 1;
      cpl = (!hold || releasing) ? imin(exp_out, hold ? 2 : 3) : 0;
      cpl_cnt = LNW'(cpl);
      exp_out = exp_out + nv - cpl;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    if (!seen) chk(1'b0, "R9 operation watchdog", guard, 0);
    chk(!done && !busy, "R9 single done pulse", int'(done), 0);
    while (exp_out > 0) begin
      chk(int'(outstanding) == exp_out, "R8 drain count", int'(outstanding), exp_out);
      cpl = imin(exp_out, LANES);
      cpl_cnt = LNW'(cpl);
      exp_out -= cpl;
      @(negedge clk);
    end
    cpl_cnt = '0;
    chk(int'(outstanding) == 0, "R8 drained", int'(outstanding), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lens[9] = '{0, 1, 5, 32, 33, 64, 65, 128, 200};
    int k;
    rst_n = 1'b0; start = 1'b0; mode = '0; ewidth = '0;
    base_in = '0; stride_in = '0; incr_in = '0; vlen = '0; cpl_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 reset flags", int'(busy), 0);
    chk(req_valid == '0, "R1 reset valid", int'(req_valid), 0);
    chk(outstanding == '0, "R1 reset outstanding", int'(outstanding), 0);
    chk(base_reg == '0, "R1 reset base", int'(base_reg), 0);
    k = 0;
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 4; w++) begin
        for (int i = 0; i < 9; i++) begin
          logic [AW-1:0] b, s, inc;
          b   = AW'(16'hFF00 + k * 40);
          s   = (w % 2 == 1) ? AW'(-24) : AW'(40 + k);
          inc = AW'(k * 3 + 1);
          run_op(m, w, b, s, inc, lens[i], (k % 2) == 1, (k % 5) == 2 && lens[i] > 8);
          k++;
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule